// File: doc/BRIEF.md
# Dual-Clock FIFO with Per-Word Occupancy Flags

This block is a shallow FIFO that moves data words from one clock domain to another. Storage is a small register array. Each word carries a pair of flag bits. One flag belongs to the producer clock and the other to the consumer clock. A word holds unread data when its two flags differ, and it is free when they match. The producer toggles its flag when it stores a word. The consumer toggles its own flag when it takes the word.

Each side keeps a private wrapping pointer. It never compares that pointer with the other side's pointer. The only traffic across the clock boundary is the flag vector of the other side, passed through a two-stage synchronizer. The producer judges full and "one slot left" from the cells at and after its pointer. The consumer judges empty and "one word left" the same way. Synchronizer lag can only make a status change late, never early. The block is meant to sit as a short elastic buffer in front of a deeper single-clock queue.

Top module: `cell_flag_fifo`

## Requirements
- R1: While a side's reset is high and afterwards until traffic arrives, `rd_empty`=1, `rd_last_out`=0, `rd_data`=0, `wr_full`=0 and `wr_last_in`=0.
- R2: Words leave `rd_data` in the order they were accepted on the write side, with no loss or duplication.
- R3: With no reads, `wr_full` goes to 1 right after the write clock edge that accepts the DEPTH-th word.
- R4: A write presented while `wr_full`=1 is discarded: nothing is stored, and the word never appears at the read side.
- R5: A read presented while `rd_empty`=1 changes nothing: `rd_data` holds its value and later words come out in order.
- R6: After a write into an empty FIFO, `rd_empty` stays 1 through the first read clock edge that follows, and falls after the second.
- R7: After a read from a full FIFO, `wr_full` stays 1 through the first write clock edge that follows, and falls after the second.
- R8: `wr_last_in`=1 exactly when the cell at the write pointer is seen free and the next cell is seen occupied (one slot left). It is never 1 together with `wr_full`.
- R9: `rd_last_out`=1 exactly when the cell at the read pointer is seen holding data and the next cell is seen free (one word left). It is never 1 together with `rd_empty`.
- R10: `rd_data` is registered. It takes the new word at the read clock edge that accepts the read, and holds it until the next accepted read.
- R11: Status never clears early. Whenever `wr_full`=0 the FIFO truly holds fewer than DEPTH words, and whenever `rd_empty`=0 it truly holds at least one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No free slot is seen at the write pointer |
| wr_last_in | output | 1 | Exactly one free slot is seen |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Last word read, registered |
| rd_empty | output | 1 | No unread word is seen at the read pointer |
| rd_last_out | output | 1 | Exactly one unread word is seen |

## Verification
A flag toggled twice, or not toggled, on one side makes a cell look wrongly occupied or wrongly free. The port view of such a fault is a duplicated, skipped or stale word on `rd_data` at the next read of that cell, which is at most DEPTH reads later. It can also show as `wr_full` or `rd_empty` stuck or released against the true fill. A wrong synchronizer depth shows within two or three cycles of the other clock: empty or full then falls one edge early or late, against the exact edge counts in R6 and R7. The random phase checks every accepted word against a reference queue, and on every cycle checks that neither status flag clears early.

// File: rtl/cff_pkg.sv
package cff_pkg;

  // Index of the cell `steps` positions after `idx` in a ring of `depth` cells.
  function automatic int unsigned ring_step(int unsigned idx, int unsigned steps,
                                            int unsigned depth);
    return (idx + steps) % depth;
  endfunction

endpackage

// File: rtl/cff_sync.sv
// Two-stage synchronizer for a vector of independently toggling flags.
module cff_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/cff_wr_ctrl.sv
// Write-domain control: owns the write flags and the write pointer.
module cff_wr_ctrl #(
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [DEPTH-1:0] rd_flags_seen,
  output logic [DEPTH-1:0] wr_flags,
  output logic [AW-1:0]    wr_ptr,
  output logic             wr_accept,
  output logic             full,
  output logic             last_in
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [DEPTH-1:0] occupied;
  logic [AW-1:0]    next_ptr;

  // A cell looks occupied while its flags differ; the read flag may be stale,
  // which only keeps the cell occupied longer.
  assign occupied  = wr_flags ^ rd_flags_seen;
  assign next_ptr  = (wr_ptr == LAST_IDX) ? '0 : wr_ptr + AW'(1);
  assign full      = occupied[wr_ptr];
  assign last_in   = !occupied[wr_ptr] &&
                     occupied[AW'(cff_pkg::ring_step(32'(wr_ptr), 1, DEPTH))];
  assign wr_accept = wr_en && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_flags <= '0;
      wr_ptr   <= '0;
    end else if (wr_accept) begin
      wr_flags[wr_ptr] <= !wr_flags[wr_ptr];
      wr_ptr           <= next_ptr;
    end
  end
endmodule

// File: rtl/cff_rd_ctrl.sv
// Read-domain control: owns the read flags and the read pointer.
module cff_rd_ctrl #(
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [DEPTH-1:0] wr_flags_seen,
  output logic [DEPTH-1:0] rd_flags,
  output logic [AW-1:0]    rd_ptr,
  output logic             rd_accept,
  output logic             empty,
  output logic             last_out
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [DEPTH-1:0] holding;
  logic [AW-1:0]    next_ptr;

  // A cell holds data while its flags differ; the write flag may be stale,
  // which only keeps the cell looking empty longer.
  assign holding   = wr_flags_seen ^ rd_flags;
  assign next_ptr  = (rd_ptr == LAST_IDX) ? '0 : rd_ptr + AW'(1);
  assign empty     = !holding[rd_ptr];
  assign last_out  = holding[rd_ptr] &&
                     !holding[AW'(cff_pkg::ring_step(32'(rd_ptr), 1, DEPTH))];
  assign rd_accept = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_flags <= '0;
      rd_ptr   <= '0;
    end else if (rd_accept) begin
      rd_flags[rd_ptr] <= !rd_flags[rd_ptr];
      rd_ptr           <= next_ptr;
    end
  end
endmodule

// File: rtl/cell_flag_fifo.sv
// Dual-clock FIFO whose occupancy is tracked by a flag pair per word.
module cell_flag_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  output logic              wr_last_in,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty,
  output logic              rd_last_out
);
  localparam int AW = $clog2(DEPTH);

  logic [DEPTH-1:0] wr_flags, rd_flags;
  logic [DEPTH-1:0] wr_flags_at_rd, rd_flags_at_wr;
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             wr_accept, rd_accept;

  logic [DATA_W-1:0] store [DEPTH];

  cff_wr_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .wr_en(wr_en),
    .rd_flags_seen(rd_flags_at_wr),
    .wr_flags(wr_flags), .wr_ptr(wr_ptr), .wr_accept(wr_accept),
    .full(wr_full), .last_in(wr_last_in)
  );

  cff_rd_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .rd_en(rd_en),
    .wr_flags_seen(wr_flags_at_rd),
    .rd_flags(rd_flags), .rd_ptr(rd_ptr), .rd_accept(rd_accept),
    .empty(rd_empty), .last_out(rd_last_out)
  );

  cff_sync #(.WIDTH(DEPTH)) u_sync_w2r (
    .clk(rd_clk), .rst(rd_rst), .async_in(wr_flags), .sync_out(wr_flags_at_rd)
  );

  cff_sync #(.WIDTH(DEPTH)) u_sync_r2w (
    .clk(wr_clk), .rst(wr_rst), .async_in(rd_flags), .sync_out(rd_flags_at_wr)
  );

  // Storage written only in the write domain; a word is read only after its
  // flag change has crossed two read-clock stages, so it is stable by then.
  always_ff @(posedge wr_clk) begin
    if (wr_accept) store[wr_ptr] <= wr_data;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst)         rd_data <= '0;
    else if (rd_accept) rd_data <= store[rd_ptr];
  end
endmodule

// File: rtl/cff_checker.sv
module cff_checker #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input logic              wr_clk,
  input logic              wr_rst,
  input logic              wr_en,
  input logic              wr_full,
  input logic              wr_last_in,
  input logic [DEPTH-1:0]  wr_flags,
  input logic [AW-1:0]     wr_ptr,
  input logic              rd_clk,
  input logic              rd_rst,
  input logic              rd_en,
  input logic              rd_empty,
  input logic              rd_last_out,
  input logic [DEPTH-1:0]  rd_flags,
  input logic [DATA_W-1:0] rd_data
);
  AST_RESET_EMPTY: assert property (@(posedge rd_clk)
    rd_rst |=> rd_empty && !rd_last_out && rd_data == '0);  // R1

  AST_RESET_NOT_FULL: assert property (@(posedge wr_clk)
    wr_rst |=> !wr_full && !wr_last_in);  // R1

  AST_ONE_TOGGLE_PER_WRITE: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_en && !wr_full) |=> $countones(wr_flags ^ $past(wr_flags)) == 1);  // R2

  AST_NO_OVERWRITE: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_en && wr_full) |=> $stable(wr_flags) && $stable(wr_ptr));  // R4

  AST_NO_UNDERRUN: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_en && rd_empty) |=> $stable(rd_flags) && $stable(rd_data));  // R5

  AST_LAST_IN_EXCL: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_last_in |-> !wr_full);  // R8

  AST_LAST_OUT_EXCL: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_last_out |-> !rd_empty);  // R9
endmodule

bind cell_flag_fifo cff_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_chk (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_full(wr_full),
  .wr_last_in(wr_last_in), .wr_flags(wr_flags), .wr_ptr(wr_ptr),
  .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_empty(rd_empty),
  .rd_last_out(rd_last_out), .rd_flags(rd_flags), .rd_data(rd_data)
);

// File: tb/cell_flag_fifo_tb.sv
`timescale 1ns/1ps
module cell_flag_fifo_tb;
  localparam int  DATA_W   = 8;
  localparam int  DEPTH    = 8;
  localparam real WR_CLK_PERIOD = 10.0;
  localparam real RD_CLK_PERIOD = 13.0;
  localparam int  RAND_CYCLES = 4000;

  logic              wr_clk = 0, rd_clk = 0;
  logic              wr_rst = 1, rd_rst = 1;
  logic              wr_en = 0, rd_en = 0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              wr_full, wr_last_in, rd_empty, rd_last_out;

  int checks = 0, failures = 0;
  bit finished = 0;
  bit wr_done = 0;
  logic [DATA_W-1:0] model_q [$];

  cell_flag_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(wr_full), .wr_last_in(wr_last_in),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_data(rd_data),
    .rd_empty(rd_empty), .rd_last_out(rd_last_out)
  );

  always #(WR_CLK_PERIOD/2) wr_clk = ~wr_clk;
  initial begin
    #3.3;
    forever #(RD_CLK_PERIOD/2) rd_clk = ~rd_clk;
  end

  function automatic logic [DATA_W-1:0] word_pattern(int i);
    return DATA_W'(8'h30 + i * 7);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic put_word(logic [DATA_W-1:0] d);
    @(negedge wr_clk);
    wr_en = 1; wr_data = d;
    if (!wr_full) model_q.push_back(d);
    @(posedge wr_clk);
    wr_en <= 0;
  endtask

  task automatic take_word(string req);
    logic [DATA_W-1:0] exp;
    @(negedge rd_clk);
    rd_en = 1;
    exp = model_q.pop_front();
    @(posedge rd_clk);
    rd_en <= 0;
    #1;
    check(req, rd_data, exp);
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_F1F0));
    repeat (5) @(posedge rd_clk);
    @(negedge wr_clk); wr_rst = 0;
    @(negedge rd_clk); rd_rst = 0;
    repeat (3) @(negedge rd_clk);
    // R1 reset state
    check("R1 empty", rd_empty, 1);
    check("R1 last_out", rd_last_out, 0);
    check("R1 rd_data", rd_data, 0);
    check("R1 full", wr_full, 0);
    check("R1 last_in", wr_last_in, 0);

    // R6 exact latency of empty release
    @(negedge wr_clk);
    wr_en = 1; wr_data = 8'h5A; model_q.push_back(8'h5A);
    @(posedge wr_clk);
    wr_en <= 0;
    @(posedge rd_clk); #0.2;
    check("R6 empty held after first read edge", rd_empty, 1);
    @(posedge rd_clk); #0.2;
    check("R6 empty released after second read edge", rd_empty, 0);
    check("R9 last_out with one word", rd_last_out, 1);
    take_word("R10 registered read data");
    check("R9 empty after last word", rd_empty, 1);

    // R5 read while empty
    @(negedge rd_clk); rd_en = 1;
    repeat (3) @(posedge rd_clk);
    rd_en <= 0;
    @(negedge rd_clk);
    check("R5 rd_data held on empty read", rd_data, 8'h5A);
    check("R5 still empty", rd_empty, 1);

    // R8 / R3 filling
    for (int i = 0; i < DEPTH - 1; i++) put_word(word_pattern(i));
    @(negedge wr_clk);
    check("R8 last_in with one slot", wr_last_in, 1);
    check("R3 not full yet", wr_full, 0);
    put_word(word_pattern(DEPTH - 1));
    #1;
    check("R3 full right after last write", wr_full, 1);
    check("R8 last_in off when full", wr_last_in, 0);

    // R4 writes while full are dropped (put_word skips the model push)
    for (int i = 0; i < 3; i++) put_word(8'hEE);
    check("R4 still full", wr_full, 1);

    // R7 exact latency of full release
    repeat (3) @(posedge rd_clk);
    @(negedge rd_clk);
    rd_en = 1;
    begin
      logic [DATA_W-1:0] exp0;
      exp0 = model_q.pop_front();
      @(posedge rd_clk);
      rd_en <= 0;
      @(posedge wr_clk); #0.2;
      check("R7 full held after first write edge", wr_full, 1);
      @(posedge wr_clk); #0.2;
      check("R7 full released after second write edge", wr_full, 0);
      check("R8 last_in after one slot frees", wr_last_in, 1);
      check("R2 first of burst", rd_data, exp0);
    end

    // drain, R2 order and R4 absence of dropped words
    while (model_q.size() > 0) begin
      @(negedge rd_clk);
      if (model_q.size() == 1) check("R9 last_out before final word", rd_last_out, 1);
      take_word("R2 in-order drain");
    end
    repeat (6) @(negedge rd_clk);
    check("R4 no dropped word stored", rd_empty, 1);

    // random phase: R2 order, R11 no early status release
    fork
      begin
        for (int c = 0; c < RAND_CYCLES; c++) begin
          @(negedge wr_clk);
          if (!wr_full) check("R11 not full implies room", model_q.size() < DEPTH, 1);
          wr_en   = ($urandom % 100) < 55;
          wr_data = DATA_W'($urandom);
          if (wr_en && !wr_full) model_q.push_back(wr_data);
        end
        @(negedge wr_clk); wr_en = 0;
        wr_done = 1;
      end
      begin
        bit pending = 0;
        logic [DATA_W-1:0] exp;
        while (!(wr_done && model_q.size() == 0 && !pending)) begin
          @(negedge rd_clk);
          if (pending) begin
            check("R2 random order", rd_data, exp);
            pending = 0;
          end
          if (!rd_empty) check("R11 not empty implies data", model_q.size() > 0, 1);
          rd_en = wr_done ? 1'b1 : (($urandom % 100) < 50);
          if (rd_en && !rd_empty) begin
            exp = model_q.pop_front();
            pending = 1;
          end
        end
        rd_en = 0;
      end
    join
    repeat (6) @(negedge rd_clk);
    check("R11 empty after random drain", rd_empty, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule